// File: doc/BRIEF.md
# Interrupt Sequencer with Vector Selection

This block is the interrupt control unit of a small 8-bit processor core. It turns four request sources into one shared entry sequence: a software break opcode, a reset request, a level-sensitive maskable interrupt and an edge-sensitive non-maskable interrupt. When a hardware request is present at an opcode fetch, the block tells the instruction register to load zero instead of the fetched byte. The core then runs the break sequence for the hardware request. The block also holds the program counter so that the interrupted instruction's address is the one pushed.

The break flag is never stored. The block produces it only while the status byte is being pushed, taken from a pending-interrupt latch. A software break therefore pushes a one and a hardware interrupt pushes a zero, and the handler can tell them apart even though both use the same vector. The latch clears when the vector low byte is read. A non-maskable interrupt that becomes pending before the vector read takes over the vector of a break or maskable interrupt already in progress. Both vector bytes always come from the same vector, and a break that is taken over in this way still pushes a one.

The surrounding core supplies the cycle strobes: the opcode fetch, the status push, the vector low read and the vector high read. The vector high read also marks the end of the sequence.

Top module: `irq_seq`

## Requirements
- R1: After block reset a reset entry is pending. `int_pend`, `b_out` and `vec_addr` read 0 until the first fetch, and the first sequence reads the vector at 0xFFFC/0xFFFD.
- R2: `ir_clear` is 1 in a fetch cycle exactly when a reset is pending, an NMI is pending, or `irq_n` is 0 while `i_flag` is 0. It is 0 in every non-fetch cycle.
- R3: `int_pend` becomes 1 in the cycle after a fetch with `ir_clear`=1 and returns to 0 in the cycle after the vector low read. A fetch with no request (software break) leaves it 0.
- R4: `b_out` is 0 outside status-push cycles. During a push it is 1 when `int_pend` is 0 (break) and 0 when `int_pend` is 1 (hardware entry).
- R5: `hold_pc` is 1 in a fetch cycle with `ir_clear`=1 and in every cycle in which `int_pend` is 1. It stays 0 for a whole software-break sequence, so the pushed return address is the one after the break.
- R6: A low `irq_n` while `i_flag` is 1 never raises `ir_clear` and never selects a vector.
- R7: A falling edge on `nmi_n` is latched as a pending NMI, which clears when its vector high byte is read. A line held low after servicing causes no second entry.
- R8: The vector low address is 0xFFFA for NMI, 0xFFFC for reset and 0xFFFE for IRQ/break. The high address, 1 greater, appears in the next cycle. Priority is reset, then NMI, then IRQ/break. `vec_addr` is 0 outside the two vector cycles.
- R9: An NMI edge sampled at least two cycles before the vector low cycle redirects the sequence in progress to the NMI vector. If that sequence is a break, the pushed `b_out` stays 1.
- R10: An NMI edge sampled one cycle before the vector low read, or later, changes neither vector byte. It remains pending and starts the next sequence.
- R11: While `res_req` is 1 a reset entry becomes pending. It takes over the vector of a sequence in progress if it arrives before the vector low read, and it clears at a vector high read while `res_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| res_req | input | 1 | Processor reset request, level |
| irq_n | input | 1 | Maskable interrupt, active-low level |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge |
| i_flag | input | 1 | Interrupt-disable flag |
| fetch | input | 1 | Opcode fetch cycle strobe |
| push_p | input | 1 | Status push cycle strobe |
| vec_lo | input | 1 | Vector low byte read cycle |
| vec_hi | input | 1 | Vector high byte read cycle, end of sequence |
| ir_clear | output | 1 | Force the opcode to 0x00 |
| int_pend | output | 1 | Hardware entry in progress |
| hold_pc | output | 1 | Suppress program counter increment |
| b_out | output | 1 | Break bit driven during the status push |
| vec_addr | output | 16 | Vector byte address during vector cycles, else 0 |

## Verification
The bench sweeps every combination of IRQ level and mask against each cycle in which an NMI edge can land, from before the fetch to the vector high read. The boundary between take-over and deferral sits between edge cycles 3 and 4. A design that armed the take-over without its registered delay would mix vectors or redirect too late. One that armed it during vector reads would fetch a low byte from one vector and a high byte from another. A break taken over by an NMI must still push B=1, so a design that derived B from the chosen vector fails. Further checks cover an NMI held low after service, which must not re-enter, and a reset request raised mid-sequence, which must take the reset vector for both bytes.

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter logic [15:0] VEC_NMI = 16'hFFFA,
  parameter logic [15:0] VEC_RST = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        res_req,
  input  logic        irq_n,
  input  logic        nmi_n,
  input  logic        i_flag,
  input  logic        fetch,
  input  logic        push_p,
  input  logic        vec_lo,
  input  logic        vec_hi,
  output logic        ir_clear,
  output logic        int_pend,
  output logic        hold_pc,
  output logic        b_out,
  output logic [15:0] vec_addr
);

  logic        nmi_q, nmi_pend, nmi_take, rst_pend, hw_pend;
  logic [15:0] lo_q, lo_now;
  logic        nmi_edge, int_req, vec_busy, nmi_serv;

  assign nmi_edge = nmi_q & ~nmi_n;
  assign int_req  = rst_pend | nmi_pend | (~irq_n & ~i_flag);
  assign vec_busy = vec_lo | vec_hi;
  assign nmi_serv = vec_hi & nmi_take & ~rst_pend;
  assign lo_now   = rst_pend ? VEC_RST : (nmi_take ? VEC_NMI : VEC_IRQ);

  assign ir_clear = fetch & int_req;
  assign int_pend = hw_pend;
  assign hold_pc  = ir_clear | hw_pend;
  assign b_out    = push_p & ~hw_pend;
  assign vec_addr = vec_lo ? lo_now : (vec_hi ? (lo_q | 16'd1) : 16'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b1;
      nmi_pend <= 1'b0;
      nmi_take <= 1'b0;
      rst_pend <= 1'b1;
      hw_pend  <= 1'b0;
      lo_q     <= 16'd0;
    end else begin
      nmi_q    <= nmi_n;
      nmi_pend <= nmi_edge | (nmi_pend & ~nmi_serv);
      nmi_take <= (nmi_pend & ~vec_busy) | (nmi_take & ~vec_hi);
      rst_pend <= (res_req & ~vec_lo) | (rst_pend & ~vec_hi);
      hw_pend  <= (fetch & int_req) | (hw_pend & ~vec_lo);
      if (vec_lo) lo_q <= lo_now;
    end
  end

  a_r3_pend_rises: assert property (@(posedge clk) disable iff (!rst_n)
    ir_clear |=> int_pend);
  a_r3_pend_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_lo && !fetch) |=> !int_pend);
  a_r7_nmi_latched: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_edge |=> nmi_pend);
  a_r8_hi_follows_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_lo ##1 vec_hi) |-> (vec_addr == ($past(vec_addr) | 16'd1)));
  a_r9_take_held: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_take && !vec_hi) |=> nmi_take);
  a_r10_no_late_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_lo && !nmi_take) |=> !nmi_take);
  a_r11_reset_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (res_req && !vec_lo) |=> rst_pend);

endmodule

// File: tb/sim_irq_seq.sv
module sim_irq_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_req = 1'b0, irq_n = 1'b1, nmi_n = 1'b1, i_flag = 1'b0;
  logic fetch = 1'b0, push_p = 1'b0, vec_lo = 1'b0, vec_hi = 1'b0;
  logic ir_clear, int_pend, hold_pc, b_out;
  logic [15:0] vec_addr;

  int checks = 0;
  int errors = 0;
  bit rstp = 1'b1;
  bit nmip = 1'b0;

  always #10 clk = ~clk;

  irq_seq u0 (
    .clk(clk), .rst_n(rst_n), .res_req(res_req), .irq_n(irq_n), .nmi_n(nmi_n),
    .i_flag(i_flag), .fetch(fetch), .push_p(push_p), .vec_lo(vec_lo),
    .vec_hi(vec_hi), .ir_clear(ir_clear), .int_pend(int_pend),
    .hold_pc(hold_pc), .b_out(b_out), .vec_addr(vec_addr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit f, input bit p, input bit lo, input bit hi);
    @(negedge clk);
    fetch = f; push_p = p; vec_lo = lo; vec_hi = hi;
    #2;
  endtask

  // j: -2 no NMI, -1 NMI edge before fetch, 0..6 NMI edge in that cycle
  task automatic run(input bit irq, input bit ifl, input int j, input bit res_mid);
    bit hw, take, rst_eff, pend_pre, serv;
    logic [15:0] lo;
    irq_n = !irq; i_flag = ifl;
    if (j == -1) begin
      nmi_n = 1'b0;
      cyc(0, 0, 0, 0);
      nmip = 1'b1;
    end
    hw = rstp | nmip | (irq & !ifl);
    take = nmip | (j >= 0 && j <= 3);
    rst_eff = rstp | res_mid;
    lo = rst_eff ? 16'hFFFC : (take ? 16'hFFFA : 16'hFFFE);
    for (int c = 0; c < 7; c++) begin
      @(negedge clk);
      if (c == j) nmi_n = 1'b0;
      res_req = res_mid && (c == 2);
      fetch = (c == 0); push_p = (c == 4); vec_lo = (c == 5); vec_hi = (c == 6);
      #2;
      if (c == 0) begin
        chk("R2 ir_clear at fetch", {15'd0, ir_clear}, {15'd0, hw});
        chk("R5 hold_pc at fetch", {15'd0, hold_pc}, {15'd0, hw});
      end else begin
        chk("R2 ir_clear off-fetch", {15'd0, ir_clear}, 16'd0);
      end
      if (c >= 1 && c <= 5) begin
        chk("R3 int_pend in sequence", {15'd0, int_pend}, {15'd0, hw});
        chk("R5 hold_pc in sequence", {15'd0, hold_pc}, {15'd0, hw});
      end
      if (c == 6) chk("R3 int_pend after vector low", {15'd0, int_pend}, 16'd0);
      if (c == 4) chk("R4 R9 b_out in push", {15'd0, b_out}, {15'd0, !hw});
      else        chk("R4 b_out outside push", {15'd0, b_out}, 16'd0);
      if (c < 5)  chk("R8 vec_addr idle", vec_addr, 16'd0);
      if (c == 5) chk("R8 R9 R10 R11 vector low", vec_addr, lo);
      if (c == 6) chk("R8 R10 vector high", vec_addr, lo + 16'd1);
    end
    pend_pre = nmip | (j >= 0 && j <= 5);
    serv = take && !rst_eff;
    nmip = (j == 6) | (pend_pre & !serv);
    rstp = 1'b0;
    res_req = 1'b0;
    if (!nmip && !(irq && !ifl)) begin
      cyc(1, 0, 0, 0);
      chk("R7 R6 no re-entry with NMI held low", {15'd0, ir_clear}, 16'd0);
    end
    @(negedge clk);
    fetch = 0; push_p = 0; vec_lo = 0; vec_hi = 0;
    nmi_n = 1'b1; irq_n = 1'b1;
    cyc(0, 0, 0, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0);
    chk("R1 int_pend after reset", {15'd0, int_pend}, 16'd0);
    chk("R1 b_out after reset", {15'd0, b_out}, 16'd0);
    chk("R1 vec_addr after reset", vec_addr, 16'd0);
    run(0, 0, -2, 0);
    for (int irq = 0; irq < 2; irq++)
      for (int ifl = 0; ifl < 2; ifl++)
        for (int j = -2; j < 7; j++)
          run(irq[0], ifl[0], j, 0);
    while (nmip) run(0, 0, -2, 0);
    run(0, 0, -2, 1);
    run(1, 0, -2, 1);
    irq_n = 1'b0; i_flag = 1'b1;
    cyc(1, 0, 0, 0);
    chk("R6 masked IRQ no clear", {15'd0, ir_clear}, 16'd0);
    cyc(0, 0, 0, 0);
    chk("R6 masked IRQ no pending", {15'd0, int_pend}, 16'd0);
    irq_n = 1'b1; i_flag = 1'b0;
    cyc(0, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule